// File: doc/BRIEF.md
# Dual-Function Input Port Controller

This block manages two groups of input pins, a 5-pin group (port A) and an 8-pin group (port B). Every pin is given one select bit. With the bit clear, the pin is an ordinary input that software reads through a data register. With the bit set, the pin is handed to an on-chip peripheral. On port A, four pins feed active-low DMA request lines and one pin feeds an active-low A/D conversion trigger. On port B, every pin is an analog channel, and its select bit drives that channel's enable.

Each pin passes through a synchroniser before it reaches either path. Software reaches the block over a byte-wide register bus that has separate read and write strobes. Read data is registered. The block has two resets. A cold reset clears all state, including the select bits. A hot reset clears the synchronisers and the read data, but the select bits keep their values.

Top module: `dual_input_port_ctrl`

## Requirements
- R1: A write to offset 0x0 loads port A select bits from wdata[4:0]. A write to offset 0x3 loads port B select bits from wdata[7:0]. Reading either offset returns the stored select bits.
- R2: While cold_rst_n is low, every select bit is 0. This holds from the first cycle of the cold reset.
- R3: A hot reset (hot_rst_n low) leaves every select bit unchanged and clears the read data to 0x00. Writes are ignored while either reset is active.
- R4: Offset 0x1 returns the port A pin levels in bits [4:0], with bit n for pin n. Offset 0x4 returns the port B pin levels in bits [7:0]. A level counts when it was held for at least two clock edges before the edge that captures the read. A high pin reads 1 and a low pin reads 0.
- R5: Bits 7:5 of offsets 0x0 and 0x1 always read 0.
- R6: A port B pin whose select bit is 1 reads 0 at offset 0x4, whatever its level.
- R7: Writes to the data offsets 0x1 and 0x4 have no effect, and neither do writes to unmapped offsets 0x2 and 0x5–0x7. The select bits stay unchanged.
- R8: A read of an unmapped offset (0x2, 0x5, 0x6, 0x7) returns 0x00.
- R9: rd_data updates on the clock edge that samples rd_en high and is valid the following cycle. It holds its value until the next read.
- R10: dma_req_n[0], [1], [2] and [3] follow the synchronised port A pins 0, 1, 3 and 4 respectively while the matching select bit is 1. Each line is 1 while its select bit is 0.
- R11: adc_trig_n follows synchronised port A pin 2 while select bit A2 is 1, and is 1 otherwise.
- R12: adc_ch_en[n] equals port B select bit n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Cold reset, asynchronous active-low, clears everything |
| hot_rst_n | input | 1 | Hot reset, asynchronous active-low, keeps select bits |
| addr | input | 3 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pin_a | input | 5 | Raw port A pins |
| pin_b | input | 8 | Raw port B pins |
| dma_req_n | output | 4 | Active-low DMA request lines |
| adc_trig_n | output | 1 | Active-low A/D external trigger |
| adc_ch_en | output | 8 | Analog channel enables |

## Verification
The bench masks port B pins with random select patterns while those pins are held high. A design that leaked the pin level into a selected bit would return nonzero data where 0 is expected. It applies a hot reset with nonzero select bits and reads them back afterwards, which catches a design that ties the select registers to the shared reset. It checks the swapped DMA mapping, where pin 2 is skipped for the trigger, and the idle-high levels when a pin is deselected, so an off-by-one pin index or an active-high default shows up on the outputs. Writes to data and unmapped offsets, reads of reserved bits, and the hold of rd_data between strobes are exercised both directed and at random.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int A_W        = 5;
  localparam int B_W        = 8;
  localparam int DATA_W     = 8;
  localparam int DMA_N      = 4;
  localparam int OFS_A_SEL  = 0;
  localparam int OFS_A_DAT  = 1;
  localparam int OFS_B_SEL  = 3;
  localparam int OFS_B_DAT  = 4;
  localparam int TRIG_PIN   = 2;

  typedef enum logic [2:0] {
    REG_A_SEL,
    REG_A_DAT,
    REG_B_SEL,
    REG_B_DAT,
    REG_NONE
  } reg_id_e;

  // DMA channel k -> port A pin index (pin TRIG_PIN is skipped)
  function automatic int dma_pin(input int k);
    return (k < TRIG_PIN) ? k : k + 1;
  endfunction
endpackage

// File: rtl/ipc_rst_sync.sv
module ipc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/ipc_pin_sync.sv
module ipc_pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_raw,
  output logic [W-1:0] pin_sync
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = pin_raw;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/ipc_regs.sv
module ipc_regs
  import ipc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_cold_n,
  input  logic              rst_any_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [A_W-1:0]    pin_a_s,
  input  logic [B_W-1:0]    pin_b_s,
  output logic [DATA_W-1:0] rd_data,
  output logic [A_W-1:0]    sel_a,
  output logic [B_W-1:0]    sel_b
);
  reg_id_e           reg_id;
  logic [A_W-1:0]    sel_a_q, sel_a_d;
  logic [B_W-1:0]    sel_b_q, sel_b_d;
  logic              sel_a_en, sel_b_en;
  logic [DATA_W-1:0] rd_q, rd_d;

  always_comb begin
    unique case (int'(addr))
      OFS_A_SEL: reg_id = REG_A_SEL;
      OFS_A_DAT: reg_id = REG_A_DAT;
      OFS_B_SEL: reg_id = REG_B_SEL;
      OFS_B_DAT: reg_id = REG_B_DAT;
      default:   reg_id = REG_NONE;
    endcase
  end

  // select register next state; writes blocked while any reset is held
  always_comb begin
    sel_a_en = wr_en && rst_any_n && (reg_id == REG_A_SEL);
    sel_b_en = wr_en && rst_any_n && (reg_id == REG_B_SEL);
    sel_a_d  = wr_data[A_W-1:0];
    sel_b_d  = wr_data[B_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_cold_n) begin
    if (!rst_cold_n) begin
      sel_a_q <= '0;
      sel_b_q <= '0;
    end else begin
      if (sel_a_en) sel_a_q <= sel_a_d;
      if (sel_b_en) sel_b_q <= sel_b_d;
    end
  end

  // read mux
  always_comb begin
    rd_d = '0;
    case (reg_id)
      REG_A_SEL: rd_d[A_W-1:0] = sel_a_q;
      REG_A_DAT: rd_d[A_W-1:0] = pin_a_s;
      REG_B_SEL: rd_d[B_W-1:0] = sel_b_q;
      REG_B_DAT: rd_d[B_W-1:0] = pin_b_s & ~sel_b_q;
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_any_n) begin
    if (!rst_any_n)  rd_q <= '0;
    else if (rd_en)  rd_q <= rd_d;
  end

  assign rd_data = rd_q;
  assign sel_a   = sel_a_q;
  assign sel_b   = sel_b_q;
endmodule

// File: rtl/ipc_periph_map.sv
module ipc_periph_map
  import ipc_pkg::*;
(
  input  logic [A_W-1:0]   sel_a,
  input  logic [B_W-1:0]   sel_b,
  input  logic [A_W-1:0]   pin_a_s,
  output logic [DMA_N-1:0] dma_req_n,
  output logic             adc_trig_n,
  output logic [B_W-1:0]   adc_ch_en
);
  for (genvar k = 0; k < DMA_N; k++) begin : g_dma
    localparam int P = dma_pin(k);
    assign dma_req_n[k] = sel_a[P] ? pin_a_s[P] : 1'b1;
  end

  assign adc_trig_n = sel_a[TRIG_PIN] ? pin_a_s[TRIG_PIN] : 1'b1;
  assign adc_ch_en  = sel_b;
endmodule

// File: rtl/dual_input_port_ctrl.sv
module dual_input_port_ctrl
  import ipc_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              hot_rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data,
  input  logic [4:0]        pin_a,
  input  logic [7:0]        pin_b,
  output logic [3:0]        dma_req_n,
  output logic              adc_trig_n,
  output logic [7:0]        adc_ch_en
);
  logic           rst_cold_n;
  logic           rst_any_n;
  logic           any_arst_n;
  logic [A_W-1:0] pin_a_s;
  logic [B_W-1:0] pin_b_s;
  logic [A_W-1:0] sel_a_q;
  logic [B_W-1:0] sel_b_q;

  assign any_arst_n = cold_rst_n & hot_rst_n;

  ipc_rst_sync #(.STAGES(2)) u_rst_cold (
    .clk(clk), .arst_n(cold_rst_n), .rst_n(rst_cold_n));
  ipc_rst_sync #(.STAGES(2)) u_rst_any (
    .clk(clk), .arst_n(any_arst_n), .rst_n(rst_any_n));

  ipc_pin_sync #(.W(A_W), .STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst_n(rst_any_n), .pin_raw(pin_a), .pin_sync(pin_a_s));
  ipc_pin_sync #(.W(B_W), .STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst_n(rst_any_n), .pin_raw(pin_b), .pin_sync(pin_b_s));

  ipc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_cold_n(rst_cold_n), .rst_any_n(rst_any_n),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .pin_a_s(pin_a_s), .pin_b_s(pin_b_s), .rd_data(rd_data),
    .sel_a(sel_a_q), .sel_b(sel_b_q));

  ipc_periph_map u_map (
    .sel_a(sel_a_q), .sel_b(sel_b_q), .pin_a_s(pin_a_s),
    .dma_req_n(dma_req_n), .adc_trig_n(adc_trig_n), .adc_ch_en(adc_ch_en));
endmodule

// File: rtl/ipc_checker.sv
module ipc_checker #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              cold_rst_n,
  input logic              hot_rst_n,
  input logic              rst_any_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic [7:0]        rd_data,
  input logic [4:0]        sel_a,
  input logic [7:0]        sel_b,
  input logic [3:0]        dma_req_n,
  input logic              adc_trig_n
);
  logic mapped;
  assign mapped = (addr == 0) || (addr == 1) || (addr == 3) || (addr == 4);

  // R2: cold reset holds every select bit at zero
  p_cold_clear_r2: assert property (@(posedge clk)
    !cold_rst_n |-> (sel_a == '0 && sel_b == '0));

  // R3: select bits survive a hot reset
  p_hot_keep_r3: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !hot_rst_n |=> ($stable(sel_a) && $stable(sel_b)));

  // R5: reserved bits of port A registers
  p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (!rst_any_n)
    (rd_en && (addr == 0 || addr == 1)) |=> (rd_data[7:5] == 3'b000));

  // R6: selected analog pins read zero
  p_adc_mask_r6: assert property (@(posedge clk) disable iff (!rst_any_n)
    (rd_en && addr == 4) |=> ((rd_data & $past(sel_b)) == 8'h00));

  // R8: unmapped offsets read zero
  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_any_n)
    (rd_en && !mapped) |=> (rd_data == 8'h00));

  // R9: read data holds without a strobe
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_any_n)
    !rd_en |=> $stable(rd_data));

  // R10: deselected DMA lines idle high
  p_dma_idle_r10: assert property (@(posedge clk) disable iff (!cold_rst_n)
    ((~{sel_a[4], sel_a[3], sel_a[1], sel_a[0]}) & ~dma_req_n) == 4'b0000);

  // R11: deselected trigger idles high
  p_trig_idle_r11: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !sel_a[2] |-> adc_trig_n);
endmodule

bind dual_input_port_ctrl ipc_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .cold_rst_n(cold_rst_n), .hot_rst_n(hot_rst_n),
  .rst_any_n(rst_any_n), .addr(addr), .rd_en(rd_en), .rd_data(rd_data),
  .sel_a(sel_a_q), .sel_b(sel_b_q), .dma_req_n(dma_req_n),
  .adc_trig_n(adc_trig_n));

// File: tb/test_dual_input_port_ctrl.sv
`timescale 1ns/1ps
module test_dual_input_port_ctrl;
  logic       clk = 1'b0;
  logic       cold_rst_n, hot_rst_n;
  logic [2:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wr_data, rd_data;
  logic [4:0] pin_a;
  logic [7:0] pin_b;
  logic [3:0] dma_req_n;
  logic       adc_trig_n;
  logic [7:0] adc_ch_en;

  int n_tests = 0;
  int n_fail  = 0;
  logic [4:0] m_sel_a;
  logic [7:0] m_sel_b;

  always #4 clk = ~clk;

  dual_input_port_ctrl i_dual_input_port_ctrl (
    .clk(clk), .cold_rst_n(cold_rst_n), .hot_rst_n(hot_rst_n),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .pin_a(pin_a), .pin_b(pin_b),
    .dma_req_n(dma_req_n), .adc_trig_n(adc_trig_n), .adc_ch_en(adc_ch_en));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {3'b000, m_sel_a};
      3'd1: return {3'b000, pin_a};
      3'd3: return m_sel_b;
      3'd4: return pin_b & ~m_sel_b;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] exp_dma();
    logic [3:0] r;
    r[0] = m_sel_a[0] ? pin_a[0] : 1'b1;
    r[1] = m_sel_a[1] ? pin_a[1] : 1'b1;
    r[2] = m_sel_a[3] ? pin_a[3] : 1'b1;
    r[3] = m_sel_a[4] ? pin_a[4] : 1'b1;
    return r;
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 3'd0) m_sel_a = d[4:0];
    if (a == 3'd3) m_sel_b = d;
  endtask

  task automatic bus_read(input logic [2:0] a, input string req);
    logic [7:0] e;
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    e = exp_read(a);
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rd_data, e);
  endtask

  task automatic set_pins(input logic [4:0] a, input logic [7:0] b);
    @(negedge clk);
    pin_a = a; pin_b = b;
    cycles(3);
  endtask

  task automatic check_outputs(input string tag);
    check({tag, " R10"}, dma_req_n, exp_dma());
    check({tag, " R11"}, adc_trig_n, m_sel_a[2] ? pin_a[2] : 1'b1);
    check({tag, " R12"}, adc_ch_en, m_sel_b);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] held;
    void'($urandom(32'hC0FFEE));
    cold_rst_n = 1'b0; hot_rst_n = 1'b1;
    addr = '0; wr_en = 0; rd_en = 0; wr_data = '0;
    pin_a = 5'h1F; pin_b = 8'hFF;
    m_sel_a = '0; m_sel_b = '0;
    cycles(3);
    check("R2 reset rd_data", rd_data, 8'h00);
    check_outputs("reset");
    cold_rst_n = 1'b1;
    cycles(4);

    // R1 select write/readback, R5 reserved bits
    bus_write(3'd0, 8'hFF);
    bus_read(3'd0, "R1/R5 sel A readback");
    bus_write(3'd3, 8'hA5);
    bus_read(3'd3, "R1 sel B readback");
    check_outputs("sel");

    // R4 pin levels, R6 masking
    set_pins(5'b10110, 8'hFF);
    bus_write(3'd0, 8'h00);
    bus_read(3'd1, "R4/R5 port A data");
    bus_read(3'd4, "R6 port B masked");
    bus_write(3'd3, 8'h00);
    bus_read(3'd4, "R4 port B unmasked");
    set_pins(5'b01001, 8'h3C);
    bus_read(3'd1, "R4 port A data 2");
    bus_read(3'd4, "R4 port B data 2");

    // R7 writes to data/unmapped offsets, R8 unmapped reads
    bus_write(3'd3, 8'h0F);
    bus_write(3'd0, 8'h15);
    for (int a = 0; a < 8; a++) begin
      if (a != 0 && a != 3) bus_write(a[2:0], 8'hFF);
    end
    bus_read(3'd0, "R7 sel A unchanged");
    bus_read(3'd3, "R7 sel B unchanged");
    bus_read(3'd2, "R8 unmapped 2");
    bus_read(3'd7, "R8 unmapped 7");

    // R10/R11 mapping walk with all pins selected
    bus_write(3'd0, 8'h1F);
    for (int p = 0; p < 5; p++) begin
      set_pins(~(5'b1 << p), pin_b);
      check_outputs("walk");
    end

    // R9 hold
    bus_read(3'd1, "R9 read");
    held = rd_data;
    set_pins(~pin_a, pin_b);
    check("R9 hold", rd_data, held);

    // R3 hot reset
    bus_write(3'd0, 8'h0A); bus_write(3'd3, 8'hC3);
    @(negedge clk); hot_rst_n = 1'b0;
    addr = 3'd0; wr_data = 8'h00; wr_en = 1'b1;
    cycles(2);
    check("R3 rd_data cleared", rd_data, 8'h00);
    wr_en = 1'b0; hot_rst_n = 1'b1;
    cycles(4);
    bus_read(3'd0, "R3 sel A kept");
    bus_read(3'd3, "R3 sel B kept");
    check_outputs("hot");

    // R2 cold reset
    @(negedge clk); cold_rst_n = 1'b0;
    m_sel_a = '0; m_sel_b = '0;
    cycles(2);
    check_outputs("cold");
    cold_rst_n = 1'b1;
    cycles(4);
    bus_read(3'd0, "R2 sel A cleared");
    bus_read(3'd3, "R2 sel B cleared");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 2);
      case (op)
        0: bus_write(3'($urandom_range(0, 7)), 8'($urandom));
        1: set_pins(5'($urandom), 8'($urandom));
        default: bus_read(3'($urandom_range(0, 7)), "R4/R6/R8 random read");
      endcase
      check_outputs("rand");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule